// File: doc/BRIEF.md
# Power-Management Event Register Window

This block is a small I/O-mapped register window for power-management events. It occupies a 64-byte aligned range of a 16-bit I/O address space. The base of the range comes from a configuration dword input, and a configuration enable bit switches decoding on or off. Inside the window, 16-bit accesses reach three registers:

- an event status register, whose bits are set by hardware and cleared by writing ones;
- an event enable register;
- a control register.

A 32-bit read reaches a free-running power-management timer.

The block drives a level interrupt. The interrupt is high whenever an event class has both its status bit and its enable bit set. Four event classes take part: timer, global-lock release, power button and real-time-clock alarm. Event sources arrive as single-cycle pulses. The timer advances on a tick-enable input. Each time its most significant bit changes, a timer event is raised, but only while the timer enable bit is set.

The access port is a single request channel with no back-pressure. The block accepts a request in every cycle that `io_valid` is high, so it has no ready signal. A read that hits the window returns `rsp_valid` with `rsp_data` one cycle later. Reads that miss get no response, and writes get no response at all.

Top module: `pm_event_block`

## Requirements
- R1: After reset, status, enable, control and the timer are all 0, `sci` is low and `rsp_valid` is low.
- R2: An access hits only when `cfg_ctl[0]` is 1 and `io_addr[15:6]` equals `cfg_base[15:6]`; `cfg_base` bits 31:16 and 5:0 are ignored. A miss changes no register and produces no response.
- R3: Only `io_addr[3:0]` selects a register (bits 5:4 are ignored). With `io_size`=0 (16-bit), offset 0 selects status, 2 selects enable and 4 selects control; every other 16-bit offset reads 0 and ignores writes.
- R4: With `io_size`=1 (32-bit), a read at offset 8 returns the timer zero-extended to 32 bits, every other offset reads 0, and every 32-bit write is ignored.
- R5: A read that hits in cycle N gives `rsp_valid`=1 in cycle N+1, with data equal to the register value before any update at that clock edge.
- R6: The status register is write-one-to-clear. Only bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC alarm) exist; all other status bits read 0.
- R7: A pulse on `evt_rtc`, `evt_pwrbtn` or `evt_glock` sets status bit 10, 8 or 5 respectively at the next edge. A set wins over a same-cycle write-one-to-clear of that bit.
- R8: The timer is a `TMR_W`-bit counter that adds 1 at each edge where `tick_en` is 1, holds otherwise, and wraps to 0.
- R9: When the timer's top bit changes, status bit 0 is set if enable bit 0 is 1 in that cycle; if enable bit 0 is 0, it is not set.
- R10: `sci` is high exactly when status AND enable is non-zero in bit 0, 5, 8 or 10. It follows the registers in the cycle after the write or event edge.
- R11: The enable and control registers store and return all 16 bits written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration dword carrying the window base (bits 15:6 used) |
| cfg_ctl | input | 8 | Configuration byte; bit 0 enables window decoding |
| io_valid | input | 1 | Access request present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_size | input | 1 | 0 = 16-bit access, 1 = 32-bit access |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 32 | Write data (bits 15:0 used by 16-bit writes) |
| tick_en | input | 1 | Timer advance enable |
| evt_rtc | input | 1 | RTC alarm pulse |
| evt_pwrbtn | input | 1 | Power-button pulse |
| evt_glock | input | 1 | Global-lock release pulse |
| sci | output | 1 | Level interrupt |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |

## Verification
The bench aims at window placement: junk in the base dword outside bits 15:6, and alias offsets whose bits 5:4 are non-zero. A decoder that used the wrong mask would miss reads or write through from outside the window. It clears status bits while the same event fires. A design that let the clear win would lose an event and leave `sci` low. It steps the timer across both changes of its top bit with the timer enable on and off, to catch a design that counts a flip only on wrap or raises status while disabled. Reads of the timer and of status in the same cycle as their update confirm that the returned data is the value before the edge.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;
  localparam int NEV   = 4;
  // event order inside the block: 0 timer, 1 global lock, 2 power button, 3 rtc
  localparam int EV_POS [NEV] = '{0, 5, 8, 10};
  localparam logic [REG_W-1:0] EVT_MASK = 16'h0521;
  localparam logic [15:0] WIN_MASK = 16'hFFC0;
  localparam logic [3:0] OFF_STS = 4'h0;
  localparam logic [3:0] OFF_EN  = 4'h2;
  localparam logic [3:0] OFF_CTL = 4'h4;
  localparam logic [3:0] OFF_TMR = 4'h8;
  typedef enum logic {ACC_W16 = 1'b0, ACC_W32 = 1'b1} acc_size_e;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
(
  input  logic [15:0] io_addr,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctl,
  output logic        win_hit,
  output logic [3:0]  win_off
);
  logic [15:0] base_masked;
  logic        unused_cfg;

  assign base_masked = cfg_base[15:0] & WIN_MASK;
  assign win_hit     = cfg_ctl[0] && ((io_addr & WIN_MASK) == base_masked);
  assign win_off     = io_addr[3:0];
  assign unused_cfg  = ^{cfg_base[31:16], cfg_ctl[7:1]};
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] count,
  output logic             msb_flip
);
  localparam int LOW_W = TMR_W - 1;

  // the top bit changes exactly when every lower bit is one and a tick arrives
  assign msb_flip = tick_en && (count[LOW_W-1:0] == {LOW_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr16,
  input  logic [3:0]       off,
  input  logic [REG_W-1:0] wdata,
  input  logic             evt_rtc,
  input  logic             evt_pwrbtn,
  input  logic             evt_glock,
  input  logic             tmr_flip,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] ctl_q,
  output logic             sci
);
  logic [NEV-1:0] sts_bits;
  logic [NEV-1:0] ev_set;
  logic [REG_W-1:0] clr_vec;

  assign clr_vec = (wr16 && off == OFF_STS) ? wdata : '0;
  assign ev_set  = {evt_rtc, evt_pwrbtn, evt_glock, tmr_flip && en_q[EV_POS[0]]};

  for (genvar i = 0; i < NEV; i++) begin : g_sts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_bits[i] <= 1'b0;
      else if (ev_set[i]) sts_bits[i] <= 1'b1;
      else if (clr_vec[EV_POS[i]]) sts_bits[i] <= 1'b0;
    end
  end

  always_comb begin
    sts_q = '0;
    for (int k = 0; k < NEV; k++) sts_q[EV_POS[k]] = sts_bits[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else if (wr16) begin
      if (off == OFF_EN)  en_q  <= wdata;
      if (off == OFF_CTL) ctl_q <= wdata;
    end
  end

  assign sci = |(sts_q & en_q & EVT_MASK);
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctl,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic        io_size,
  input  logic [15:0] io_addr,
  input  logic [31:0] io_wdata,
  input  logic        tick_en,
  input  logic        evt_rtc,
  input  logic        evt_pwrbtn,
  input  logic        evt_glock,
  output logic        sci,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  logic             win_hit;
  logic [3:0]       win_off;
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_flip;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic             wr16;
  logic [31:0]      rd_mux;
  logic             unused_wd;

  assign unused_wd = ^io_wdata[31:REG_W];

  pm_win_decode u_dec (
    .io_addr (io_addr),
    .cfg_base(cfg_base),
    .cfg_ctl (cfg_ctl),
    .win_hit (win_hit),
    .win_off (win_off)
  );

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .count   (tmr_q),
    .msb_flip(tmr_flip)
  );

  assign wr16 = io_valid && io_write && win_hit && (acc_size_e'(io_size) == ACC_W16);

  pm_evt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr16      (wr16),
    .off       (win_off),
    .wdata     (io_wdata[REG_W-1:0]),
    .evt_rtc   (evt_rtc),
    .evt_pwrbtn(evt_pwrbtn),
    .evt_glock (evt_glock),
    .tmr_flip  (tmr_flip),
    .sts_q     (sts_q),
    .en_q      (en_q),
    .ctl_q     (ctl_q),
    .sci       (sci)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_size_e'(io_size) == ACC_W16) begin
      case (win_off)
        OFF_STS: rd_mux = 32'(sts_q);
        OFF_EN:  rd_mux = 32'(en_q);
        OFF_CTL: rd_mux = 32'(ctl_q);
        default: rd_mux = '0;
      endcase
    end else if (win_off == OFF_TMR) begin
      rd_mux = 32'(tmr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= io_valid && !io_write && win_hit;
      if (io_valid && !io_write && win_hit) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/pm_event_checker.sv
module pm_event_checker #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_valid,
  input logic             io_write,
  input logic             win_hit,
  input logic             tick_en,
  input logic             evt_rtc,
  input logic             evt_pwrbtn,
  input logic             evt_glock,
  input logic [15:0]      sts_q,
  input logic [15:0]      en_q,
  input logic [15:0]      ctl_q,
  input logic [TMR_W-1:0] tmr_q,
  input logic             sci,
  input logic             rsp_valid
);
  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && win_hit) |=> rsp_valid); // R5
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(io_valid && !io_write)); // R5
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !win_hit) |=> ($stable(en_q) && $stable(ctl_q))); // R2
  AST_PWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pwrbtn |=> sts_q[8]); // R7
  AST_RTC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rtc |=> sts_q[10]); // R7
  AST_GLK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_glock |=> sts_q[5]); // R7
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tmr_q)); // R8
  AST_TMR_STS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(en_q[0])); // R9
  AST_SCI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past(io_valid || evt_rtc || evt_pwrbtn || evt_glock || tick_en)); // R10
endmodule

bind pm_event_block pm_event_checker #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_valid  (io_valid),
  .io_write  (io_write),
  .win_hit   (win_hit),
  .tick_en   (tick_en),
  .evt_rtc   (evt_rtc),
  .evt_pwrbtn(evt_pwrbtn),
  .evt_glock (evt_glock),
  .sts_q     (sts_q),
  .en_q      (en_q),
  .ctl_q     (ctl_q),
  .tmr_q     (tmr_q),
  .sci       (sci),
  .rsp_valid (rsp_valid)
);

// File: tb/pm_event_block_test.sv
`timescale 1ns/1ps
module pm_event_block_test;
  localparam int TW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h0;
  logic [7:0]  cfg_ctl = 8'h0;
  logic        io_valid = 1'b0, io_write = 1'b0, io_size = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [31:0] io_wdata = 32'h0;
  logic        tick_en = 1'b0, evt_rtc = 1'b0, evt_pwrbtn = 1'b0, evt_glock = 1'b0;
  logic        sci, rsp_valid;
  logic [31:0] rsp_data;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  logic [15:0]   m_sts = 0, m_en = 0, m_ctl = 0;
  logic [TW-1:0] m_tmr = 0;

  always #4 clk = ~clk;

  pm_event_block #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ctl(cfg_ctl),
    .io_valid(io_valid), .io_write(io_write), .io_size(io_size),
    .io_addr(io_addr), .io_wdata(io_wdata), .tick_en(tick_en),
    .evt_rtc(evt_rtc), .evt_pwrbtn(evt_pwrbtn), .evt_glock(evt_glock),
    .sci(sci), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic sz, input logic [3:0] off);
    if (!sz) begin
      case (off)
        4'h0: return 32'(m_sts);
        4'h2: return 32'(m_en);
        4'h4: return 32'(m_ctl);
        default: return 32'h0;
      endcase
    end
    return (off == 4'h8) ? 32'(m_tmr) : 32'h0;
  endfunction

  function automatic string rtag(input logic sz, input logic [3:0] off);
    if (sz) return (off == 4'h8) ? "R4_tmr" : "R4_other";
    case (off)
      4'h0: return "R6_sts";
      4'h2, 4'h4: return "R11_rw";
      default: return "R3_other";
    endcase
  endfunction

  function automatic bit mhit(input logic [15:0] a);
    return cfg_ctl[0] && ((a & 16'hFFC0) == (cfg_base[15:0] & 16'hFFC0));
  endfunction

  // one cycle: drive, advance model, compare after the edge
  task automatic step(input logic v, w, sz, input logic [15:0] a, input logic [31:0] wd,
                      input logic r, p, g, t);
    logic hit, flip, exp_v;
    logic [31:0] exp_d;
    logic [15:0] clr, setv, n_sts, n_en, n_ctl;
    string tg;
    io_valid = v; io_write = w; io_size = sz; io_addr = a; io_wdata = wd;
    evt_rtc = r; evt_pwrbtn = p; evt_glock = g; tick_en = t;
    hit   = mhit(a);
    exp_v = v && !w && hit;
    exp_d = mread(sz, a[3:0]);
    tg    = hit ? rtag(sz, a[3:0]) : "R2_miss";
    flip  = t && (m_tmr[TW-2:0] == {(TW-1){1'b1}});
    clr   = (v && w && hit && !sz && a[3:0] == 4'h0) ? wd[15:0] : 16'h0;
    setv  = 16'h0;
    setv[10] = r; setv[8] = p; setv[5] = g; setv[0] = flip && m_en[0];
    n_sts = ((m_sts & ~clr) | setv) & 16'h0521;
    n_en  = (v && w && hit && !sz && a[3:0] == 4'h2) ? wd[15:0] : m_en;
    n_ctl = (v && w && hit && !sz && a[3:0] == 4'h4) ? wd[15:0] : m_ctl;
    @(posedge clk);
    @(negedge clk);
    m_sts = n_sts; m_en = n_en; m_ctl = n_ctl;
    if (t) m_tmr = m_tmr + 1'b1;
    chk(rsp_valid === exp_v, (exp_v || !hit) ? tg : "R5_valid", 32'(rsp_valid), 32'(exp_v));
    if (exp_v) chk(rsp_data === exp_d, tg, rsp_data, exp_d);
    chk(sci === |(m_sts & m_en & 16'h0521), "R10_sci", 32'(sci), 32'(|(m_sts & m_en & 16'h0521)));
    io_valid = 0; evt_rtc = 0; evt_pwrbtn = 0; evt_glock = 0; tick_en = 0;
  endtask

  task automatic idle(input logic t);
    step(0, 0, 0, 16'h0, 32'h0, 0, 0, 0, t);
  endtask

  task automatic rd(input logic sz, input logic [15:0] a);
    step(1, 0, sz, a, 32'h0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    step(1, 1, 0, a, d, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [15:0] b;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sci === 1'b0, "R1_sci", 32'(sci), 0);
    chk(rsp_valid === 1'b0, "R1_rsp", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    cfg_base = 32'hABCD_123F;   // junk outside bits 15:6
    cfg_ctl  = 8'hFE;           // window disabled
    b = 16'h1200;
    // R2: writes with window off are ignored
    wr(b | 16'h2, 32'h0000_FFFF);
    cfg_ctl = 8'h01;
    rd(0, b | 16'h2);
    chk(rsp_data === 32'h0, "R2_disabled_write", rsp_data, 0);
    rd(0, b); rd(0, b | 16'h4); rd(1, b | 16'h8);
    chk(rsp_data === 32'h0, "R1_tmr_zero", rsp_data, 0);
    // R2: outside window
    wr(16'h1240, 32'h0000_1234);
    rd(0, b | 16'h4);
    chk(rsp_data === 32'h0, "R2_outside", rsp_data, 0);
    // R3: alias through bits 5:4, R11 full width
    wr(b | 16'h34, 32'hFFFF_A5C3);
    rd(0, b | 16'h4);
    chk(rsp_data === 32'h0000_A5C3, "R11_ctl", rsp_data, 32'h0000_A5C3);
    // R4: 32-bit writes ignored
    step(1, 1, 1, b | 16'h2, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(0, b | 16'h2);
    chk(rsp_data === 32'h0, "R4_w32_ignored", rsp_data, 0);
    // R7/R10: power button raises sci when enabled
    wr(b | 16'h2, 32'h0000_0521);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(sci === 1'b1, "R7_pwr_sci", 32'(sci), 1);
    // R7: set wins over same-cycle clear
    step(1, 1, 0, b, 32'h0000_0400, 1, 0, 0, 0);
    rd(0, b);
    chk(rsp_data === 32'h0000_0500, "R7_set_wins", rsp_data, 32'h0000_0500);
    // R6: W1C clears both
    wr(b, 32'h0000_FFFF);
    chk(sci === 1'b0, "R6_w1c", 32'(sci), 0);
    // R9: timer flip with enable off: no status
    wr(b | 16'h2, 32'h0000_0000);
    repeat (130) idle(1);
    rd(0, b);
    chk(rsp_data === 32'h0, "R9_no_en", rsp_data, 0);
    // R8: timer value after 130 ticks
    rd(1, b | 16'h8);
    chk(rsp_data === 32'd130, "R8_count", rsp_data, 32'd130);
    // R9: flip on wrap with enable on
    wr(b | 16'h2, 32'h0000_0001);
    repeat (126) idle(1);
    rd(0, b);
    chk(rsp_data === 32'h1, "R9_wrap_sets", rsp_data, 1);
    chk(sci === 1'b1, "R9_sci", 32'(sci), 1);
    wr(b, 32'h1);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] off;
      logic [15:0] a;
      if (n % 700 == 699) begin
        cfg_base = {$urandom, 6'h0} ^ 32'(($urandom % 64));
        cfg_ctl  = 8'($urandom) | ((n % 1400 == 699) ? 8'h0 : 8'h1);
      end
      case ($urandom % 6)
        0: off = 4'h0; 1: off = 4'h2; 2: off = 4'h4; 3: off = 4'h8;
        4: off = 4'h6; default: off = 4'($urandom);
      endcase
      a = ($urandom % 4 != 0) ? ((cfg_base[15:0] & 16'hFFC0) | 16'(($urandom % 4) << 4) | 16'(off))
                              : 16'($urandom);
      step($urandom % 3 != 0, $urandom % 2, $urandom % 4 == 0, a,
           ($urandom % 2) ? $urandom : 32'($urandom % 2),
           $urandom % 8 == 0, $urandom % 8 == 0, $urandom % 8 == 0, $urandom % 4 != 0);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule